// File: doc/BRIEF.md
# Integrate-Then-Read Frame Timing Generator

This block sits on the camera side of a snapshot infrared readout chip and produces the three timing strobes that chip needs: a frame strobe, a per-row line strobe and a field strobe. Each frame begins when the frame strobe goes high. One clock later a burst of line strobes starts, one for each row. The frame strobe stays high until the last row has had time to shift out. The integration interval is counted from the falling edge of the frame strobe. A fixed reset gap follows, and then the next frame begins. The readout and integration intervals do not overlap, so a frame lasts the readout time plus the integration time plus the reset gap.

The spacing between line strobes comes from the row length and the number of video outputs in use. The readout chip delivers two pixels per clock, and those pixels are split across the active outputs. The generator therefore leaves enough clocks for a whole row to leave the chip. All configuration inputs are captured at the start of each frame. When interlace is enabled, the field strobe changes level once per frame.

Top module: `itr_frame_timer`

## Requirements
- R1: While `rst` is high, `fsync`, `lsync` and `field` are low. The first frame starts on the first rising clock edge at which `rst` is low.
- R2: `fsync` goes high at frame start and stays high for exactly 1 + rows × P clocks, where P is the line period from R4.
- R3: `lsync` pulses once per row. Each pulse is one clock wide. The first pulse comes one clock after `fsync` rises, and the pulses are P clocks apart.
- R4: The line period is P = max(2, ceil(`ppr_cfg` / (2·N))). N is the number of outputs, selected by `out_sel`: 0 gives N=1, 1 gives N=2, and 2 or 3 gives N=4.
- R5: `lsync` changes only on a falling clock edge, half a period after the rising edge at which the pulse is decided.
- R6: After `fsync` falls, it stays low for `int_cfg` + RESET_CLKS clocks: integration for `int_cfg` clocks, then the reset gap. The next frame then starts.
- R7: `rows_cfg`, `ppr_cfg`, `int_cfg`, `out_sel` and `interlace_en` are sampled only on the frame-start edge. Changing them during a frame has no effect on that frame.
- R8: At each frame start, `field` inverts if `interlace_en` is sampled high, and is driven low if it is sampled low. `field` changes at no other time.
- R9: A value of zero in `rows_cfg` or in `int_cfg` acts as one.
- R10: `lsync` is never high while `fsync` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rows_cfg | input | ROW_W | Rows read per frame |
| ppr_cfg | input | PIX_W | Pixels per row |
| int_cfg | input | INT_W | Integration time in clocks |
| out_sel | input | 2 | Output count code (0:1, 1:2, 2/3:4) |
| interlace_en | input | 1 | Enables field toggling |
| fsync | output | 1 | Frame strobe, high through readout |
| lsync | output | 1 | Line strobe, one clock per row, falling-edge launched |
| field | output | 1 | Field strobe for interlaced readout |

## Verification
Two functions can land on the same clock edge. The first is the capture of new configuration at frame start. The second is a configuration change made by the host at that moment, and the field flip happens on the same edge. The bench changes its inputs at random cycles, so some changes fall in the cycle just before a frame-start edge. Its reference model takes whatever values were present at that edge and uses them to judge the whole following frame, including the field level. Any lsync, fsync or field value that disagrees with that model is counted as a miscompare.

// File: rtl/itr_timer_pkg.sv
package itr_timer_pkg;

  typedef enum logic [1:0] {
    ST_HEAD  = 2'd0,
    ST_LINE  = 2'd1,
    ST_INTEG = 2'd2,
    ST_GAP   = 2'd3
  } tstate_e;

endpackage

// File: rtl/tg_line_period.sv
// Clocks between line strobes: rows leave at two pixels per clock,
// split across 1, 2 or 4 outputs; never fewer than 2 clocks.
module tg_line_period #(
  parameter int PIX_W = 11
) (
  input  logic [PIX_W-1:0] ppr,
  input  logic [1:0]       sel,
  output logic [PIX_W-1:0] period
);
  localparam int SUM_W = PIX_W + 1;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] quot;

  always_comb begin
    case (sel)
      2'd0:    sum = SUM_W'(ppr) + SUM_W'(1);
      2'd1:    sum = SUM_W'(ppr) + SUM_W'(3);
      default: sum = SUM_W'(ppr) + SUM_W'(7);
    endcase
    case (sel)
      2'd0:    quot = sum >> 1;
      2'd1:    quot = sum >> 2;
      default: quot = sum >> 3;
    endcase
    if (quot < SUM_W'(2)) period = PIX_W'(2);
    else                  period = quot[PIX_W-1:0];
  end
endmodule

// File: rtl/tg_fall_stage.sv
// Launches the line strobe from the falling clock edge.
module tg_fall_stage (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(negedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/itr_frame_timer.sv
module itr_frame_timer
  import itr_timer_pkg::*;
#(
  parameter int ROW_W      = 10,
  parameter int PIX_W      = 11,
  parameter int INT_W      = 16,
  parameter int RESET_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] rows_cfg,
  input  logic [PIX_W-1:0] ppr_cfg,
  input  logic [INT_W-1:0] int_cfg,
  input  logic [1:0]       out_sel,
  input  logic             interlace_en,
  output logic             fsync,
  output logic             lsync,
  output logic             field
);
  localparam int CNT_W = (INT_W > PIX_W) ? INT_W : PIX_W;
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(RESET_CLKS - 1);

  tstate_e          state;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] row_left;
  logic [ROW_W-1:0] rows_q;
  logic [PIX_W-1:0] ppr_q;
  logic [INT_W-1:0] int_q;
  logic [1:0]       sel_q;
  logic             fsync_q;
  logic             field_q;
  logic             lreq;
  logic [PIX_W-1:0] period;

  tg_line_period #(.PIX_W(PIX_W)) u_period (
    .ppr    (ppr_q),
    .sel    (sel_q),
    .period (period)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_GAP;
      cnt      <= '0;
      row_left <= '0;
      rows_q   <= '0;
      ppr_q    <= '0;
      int_q    <= '0;
      sel_q    <= '0;
      fsync_q  <= 1'b0;
      field_q  <= 1'b0;
      lreq     <= 1'b0;
    end else begin
      lreq <= 1'b0;
      case (state)
        ST_GAP: begin
          if (cnt == '0) begin
            rows_q  <= (rows_cfg == '0) ? ROW_W'(1) : rows_cfg;
            int_q   <= (int_cfg == '0) ? INT_W'(1) : int_cfg;
            ppr_q   <= ppr_cfg;
            sel_q   <= out_sel;
            fsync_q <= 1'b1;
            field_q <= interlace_en ? ~field_q : 1'b0;
            state   <= ST_HEAD;
          end else begin
            cnt <= cnt - C_ONE;
          end
        end
        ST_HEAD: begin
          lreq     <= 1'b1;
          row_left <= rows_q - ROW_W'(1);
          cnt      <= CNT_W'(period) - C_ONE;
          state    <= ST_LINE;
        end
        ST_LINE: begin
          if (cnt != '0) begin
            cnt <= cnt - C_ONE;
          end else if (row_left != '0) begin
            lreq     <= 1'b1;
            row_left <= row_left - ROW_W'(1);
            cnt      <= CNT_W'(period) - C_ONE;
          end else begin
            fsync_q <= 1'b0;
            cnt     <= CNT_W'(int_q) - C_ONE;
            state   <= ST_INTEG;
          end
        end
        default: begin
          if (cnt != '0) begin
            cnt <= cnt - C_ONE;
          end else begin
            cnt   <= GAP_LOAD;
            state <= ST_GAP;
          end
        end
      endcase
    end
  end

  tg_fall_stage u_fall (
    .clk (clk),
    .rst (rst),
    .d   (lreq),
    .q   (lsync)
  );

  assign fsync = fsync_q;
  assign field = field_q;
endmodule

// File: rtl/itr_frame_timer_chk.sv
module itr_frame_timer_chk (
  input logic clk,
  input logic rst,
  input logic fsync,
  input logic lsync,
  input logic field,
  input logic interlace_en
);
  p_line_in_frame_r10: assert property (@(posedge clk) disable iff (rst)
    lsync |-> fsync);

  p_line_single_r3: assert property (@(posedge clk) disable iff (rst)
    lsync |=> !lsync);

  p_lead_clock_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync) |-> !lsync);

  p_field_at_start_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(field) |-> $rose(fsync));

  p_field_low_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(fsync) && !$past(interlace_en)) |-> !field);

  p_field_flip_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(fsync) && $past(interlace_en)) |-> (field != $past(field)));
endmodule

bind itr_frame_timer itr_frame_timer_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .fsync        (fsync),
  .lsync        (lsync),
  .field        (field),
  .interlace_en (interlace_en)
);

// File: tb/tb_itr_frame_timer.sv
module tb_itr_frame_timer;
  localparam int ROW_W = 10;
  localparam int PIX_W = 11;
  localparam int INT_W = 16;
  localparam int RESET_CLKS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ROW_W-1:0] rows_cfg = 10'd3;
  logic [PIX_W-1:0] ppr_cfg = 11'd16;
  logic [INT_W-1:0] int_cfg = 16'd5;
  logic [1:0] out_sel = 2'd0;
  logic interlace_en = 1'b1;
  logic fsync, lsync, field;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // model state
  int off = 0;
  int m_rows, m_p, m_t;
  bit m_field = 1'b0;
  bit prev_ls = 1'b0;
  string phase = "R7";

  always #4 clk = ~clk;

  itr_frame_timer #(.ROW_W(ROW_W), .PIX_W(PIX_W), .INT_W(INT_W),
                    .RESET_CLKS(RESET_CLKS)) dut (
    .clk(clk), .rst(rst), .rows_cfg(rows_cfg), .ppr_cfg(ppr_cfg),
    .int_cfg(int_cfg), .out_sel(out_sel), .interlace_en(interlace_en),
    .fsync(fsync), .lsync(lsync), .field(field));

  // R4: line period from row length and output count
  function automatic int line_period(int ppr, int sel);
    int n = (sel == 0) ? 1 : (sel == 1) ? 2 : 4;
    int p = (ppr + 2 * n - 1) / (2 * n);
    return (p < 2) ? 2 : p;
  endfunction

  function automatic int frame_len(int rows, int p, int t);
    return 1 + rows * p + t + RESET_CLKS;
  endfunction

  task automatic step(input bit rnd);
    bit e_fs, e_ls;
    @(posedge clk);
    #2;
    vectors++;
    // R5: lsync still holds the previous value before the falling edge
    if (lsync !== prev_ls) begin
      miscompares++;
      $display("FAIL R5 early lsync=%b expected %b", lsync, prev_ls);
    end
    #4;
    if (off == 0) begin
      // R7/R9: capture at frame start, zeros act as one
      m_rows = (rows_cfg == 0) ? 1 : int'(rows_cfg);
      m_t = (int_cfg == 0) ? 1 : int'(int_cfg);
      m_p = line_period(int'(ppr_cfg), int'(out_sel));
      m_field = interlace_en ? ~m_field : 1'b0;
    end
    e_fs = (off <= m_rows * m_p);
    e_ls = (off >= 1) && (off <= 1 + (m_rows - 1) * m_p) && ((off - 1) % m_p == 0);
    vectors++;
    if (fsync !== e_fs) begin
      miscompares++;
      $display("FAIL R2/R6 (%s) off=%0d fsync=%b expected %b", phase, off, fsync, e_fs);
    end else if (lsync !== e_ls) begin
      miscompares++;
      $display("FAIL R3 (%s) off=%0d lsync=%b expected %b", phase, off, lsync, e_ls);
    end else if (field !== m_field) begin
      miscompares++;
      $display("FAIL R8 (%s) off=%0d field=%b expected %b", phase, off, field, m_field);
    end else if (lsync && !fsync) begin
      miscompares++;
      $display("FAIL R10 lsync=%b expected 0 outside frame", lsync);
    end
    prev_ls = e_ls;
    off++;
    if (off == frame_len(m_rows, m_p, m_t)) off = 0;
    if (rnd && ($urandom % 40 == 0)) begin
      rows_cfg = ROW_W'($urandom % 7);
      ppr_cfg = PIX_W'($urandom % 48);
      int_cfg = INT_W'($urandom % 24);
      out_sel = 2'($urandom % 4);
      interlace_en = 1'($urandom % 2);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) begin
      @(posedge clk);
      #6;
      vectors++;
      // R1: quiet outputs during reset
      if (fsync !== 1'b0 || lsync !== 1'b0 || field !== 1'b0) begin
        miscompares++;
        $display("FAIL R1 outputs %b%b%b expected 000", fsync, lsync, field);
      end
    end
    rst = 1'b0;
    // R1: first frame starts at the first edge after release (off 0)
    phase = "R1";
    repeat (200) step(1'b0);
    // R7: random mid-frame changes must not disturb the running frame
    phase = "R7";
    repeat (3000) step(1'b1);
    // R9: zero rows and zero integration act as one
    phase = "R9";
    rows_cfg = '0; int_cfg = '0; ppr_cfg = 11'd10; out_sel = 2'd1;
    repeat (300) step(1'b0);
    // R4: minimum period of two clocks
    phase = "R4";
    rows_cfg = 10'd5; ppr_cfg = 11'd1; out_sel = 2'd0; int_cfg = 16'd3;
    repeat (300) step(1'b0);
    // R4: longest row with four outputs
    ppr_cfg = 11'd2047; out_sel = 2'd3; rows_cfg = 10'd2;
    repeat (1200) step(1'b0);
    // R8: interlace off then on
    phase = "R8";
    ppr_cfg = 11'd20; out_sel = 2'd2; rows_cfg = 10'd4; int_cfg = 16'd7;
    interlace_en = 1'b0;
    repeat (300) step(1'b0);
    interlace_en = 1'b1;
    repeat (300) step(1'b0);
    // R6/R10: long random run
    phase = "R6";
    repeat (2000) step(1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired, run incomplete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule